// File: doc/BRIEF.md
# Interrupt Pin and Message Router

This block gathers level-sensitive interrupt requests from internal sources, removes the ones the host has masked, and presents the rest to the host. It has two delivery methods. In pin mode each source is steered by its own routing bits to a primary active-low pin, an alternate active-low pin, both, or neither. In message mode both pins stay deasserted and each source that becomes pending produces one message write, described by an address, a data word and the source index.

Message mode has two forms. Single-message mode uses one shared address/data pair for every source. Multi-vector mode gives each source its own address and data words. Writes go out one at a time, lowest source index first. Each write is held on the outputs until the bus side returns a one-cycle done pulse. A change of delivery mode is applied only when no write is outstanding.

Top module: `irq_router`

## Requirements
- R1: After reset both `irq_pri_n` and `irq_alt_n` are high and `msg_valid` is low.
- R2: In pin mode (`mode_sel` = 2'b00, or 2'b11, which also selects pins), `irq_pri_n` goes low one cycle after any unmasked requesting source has its primary routing bit `route_cfg[2*i]` set. It returns high one cycle after no such source remains.
- R3: In pin mode, `irq_alt_n` follows the sources whose alternate bit `route_cfg[2*i+1]` is set, with the same timing as R2. A source with both bits set drives both pins. A source with both bits clear drives neither pin.
- R4: A source whose `host_mask[i]` bit is 1 has no effect on either pin and produces no message write.
- R5: Once single-message mode (2'b01) or multi-vector mode (2'b10) is in effect, both pins stay high whatever the requests and routing bits are.
- R6: In message mode, a source that becomes pending (requesting and unmasked) produces exactly one write. Its next write comes only after it has stopped being pending and then become pending again.
- R7: Only one write is outstanding at any time. When several sources are waiting, the lowest source index is written first. The next write appears no earlier than the cycle after the done pulse.
- R8: In single-message mode every write carries `single_addr` and `single_data`, and `msg_src` gives the source index.
- R9: In multi-vector mode a write for source i carries `vec_addr[i*ADDR_W +: ADDR_W]` and `vec_data[i*DATA_W +: DATA_W]`.
- R10: A new `mode_sel` value takes effect only in a cycle when no write is outstanding.
- R11: While `msg_valid` is high and `msg_done` is low, `msg_addr`, `msg_data` and `msg_src` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | NUM_SRC | Level request from each source |
| host_mask | input | NUM_SRC | 1 blocks the matching source |
| route_cfg | input | 2*NUM_SRC | Per-source pin steering: bit 2i primary, bit 2i+1 alternate |
| mode_sel | input | 2 | 00/11 pins, 01 single message, 10 multi-vector |
| single_addr | input | ADDR_W | Shared message address |
| single_data | input | DATA_W | Shared message data |
| vec_addr | input | NUM_SRC*ADDR_W | Per-source message address |
| vec_data | input | NUM_SRC*DATA_W | Per-source message data |
| msg_done | input | 1 | One-cycle pulse that completes the outstanding write |
| irq_pri_n | output | 1 | Primary interrupt pin, active low |
| irq_alt_n | output | 1 | Alternate interrupt pin, active low |
| msg_valid | output | 1 | A message write is outstanding |
| msg_addr | output | ADDR_W | Address of the outstanding write |
| msg_data | output | DATA_W | Data of the outstanding write |
| msg_src | output | $clog2(NUM_SRC) | Source index of the outstanding write |

## Verification
The pins are driven in turn by single sources with each of the four routing codes, so primary-only, alternate-only, both and neither steering can be told apart. Several sources are then raised in the same cycle in multi-vector mode, which exposes any error in priority order or in the per-vector address and data selection. A source that stays pending after its write separates an edge-triggered issue from a level-triggered one. A masked source, and a mode change made while a write is outstanding, show whether masking and the deferred mode switch work as intended.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    typedef enum logic [1:0] {
        MODE_PIN    = 2'b00,
        MODE_SINGLE = 2'b01,
        MODE_MULTI  = 2'b10,
        MODE_PIN_R  = 2'b11
    } irq_mode_e;

    function automatic logic mode_is_msg(irq_mode_e m);
        return (m == MODE_SINGLE) || (m == MODE_MULTI);
    endfunction

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N    = 8,
    localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv #(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   pending,
    input  logic [2*N-1:0] route,
    input  logic           pins_en,
    output logic           pri_n,
    output logic           alt_n
);
    localparam int NPIN = 2;

    typedef struct packed {
        logic [NPIN-1:0] pin_n;
    } pin_state_t;

    pin_state_t st_d, st_q;
    logic [NPIN-1:0] hit;

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        logic [N-1:0] sel;
        for (genvar i = 0; i < N; i++) begin : g_src
            assign sel[i] = route[2*i + p];
        end
        assign hit[p] = |(pending & sel);
    end

    always_comb begin
        st_d = st_q;
        for (int p = 0; p < NPIN; p++) begin
            st_d.pin_n[p] = ~(pins_en & hit[p]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pin_n: '1};
        else        st_q <= st_d;
    end

    assign pri_n = st_q.pin_n[0];
    assign alt_n = st_q.pin_n[1];
endmodule

// File: rtl/irq_msg_ctrl.sv
module irq_msg_ctrl
    import irq_router_pkg::*;
#(
    parameter int N       = 8,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    localparam int IW     = (N > 1) ? $clog2(N) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        pending,
    input  irq_mode_e           mode,
    input  logic [ADDR_W-1:0]   single_addr,
    input  logic [DATA_W-1:0]   single_data,
    input  logic [N*ADDR_W-1:0] vec_addr,
    input  logic [N*DATA_W-1:0] vec_data,
    input  logic                done,
    output logic                valid,
    output logic [ADDR_W-1:0]   addr,
    output logic [DATA_W-1:0]   data,
    output logic [IW-1:0]       src
);
    typedef struct packed {
        logic [N-1:0]      sent;
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [IW-1:0]     src;
    } msg_state_t;

    msg_state_t st_d, st_q;
    logic [N-1:0] eligible;
    logic         pick_found;
    logic [IW-1:0] pick_idx;
    logic         msg_on;

    assign msg_on   = mode_is_msg(mode);
    assign eligible = pending & ~st_q.sent;

    irq_prio_pick #(.N(N)) u_pick (
        .req   (eligible),
        .found (pick_found),
        .idx   (pick_idx)
    );

    always_comb begin
        st_d = st_q;
        // a source that drops out of pending is re-armed
        st_d.sent = st_q.sent & pending;
        if (!msg_on) begin
            st_d.sent = '0;
        end
        if (st_q.valid && done) begin
            st_d.valid = 1'b0;
        end
        if (!st_q.valid && msg_on && pick_found) begin
            st_d.valid          = 1'b1;
            st_d.src            = pick_idx;
            st_d.sent[pick_idx] = 1'b1;
            if (mode == MODE_MULTI) begin
                st_d.addr = vec_addr[pick_idx*ADDR_W +: ADDR_W];
                st_d.data = vec_data[pick_idx*DATA_W +: DATA_W];
            end else begin
                st_d.addr = single_addr;
                st_d.data = single_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid = st_q.valid;
    assign addr  = st_q.addr;
    assign data  = st_q.data;
    assign src   = st_q.src;
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    localparam int IW     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        src_req,
    input  logic [NUM_SRC-1:0]        host_mask,
    input  logic [2*NUM_SRC-1:0]      route_cfg,
    input  logic [1:0]                mode_sel,
    input  logic [ADDR_W-1:0]         single_addr,
    input  logic [DATA_W-1:0]         single_data,
    input  logic [NUM_SRC*ADDR_W-1:0] vec_addr,
    input  logic [NUM_SRC*DATA_W-1:0] vec_data,
    input  logic                      msg_done,
    output logic                      irq_pri_n,
    output logic                      irq_alt_n,
    output logic                      msg_valid,
    output logic [ADDR_W-1:0]         msg_addr,
    output logic [DATA_W-1:0]         msg_data,
    output logic [IW-1:0]             msg_src
);
    typedef struct packed {
        irq_mode_e mode;
    } top_state_t;

    top_state_t st_d, st_q;
    irq_mode_e  cur_mode_q;
    logic [NUM_SRC-1:0] pending;

    assign pending    = src_req & ~host_mask;
    assign cur_mode_q = st_q.mode;

    always_comb begin
        st_d = st_q;
        if (!msg_valid) begin
            st_d.mode = irq_mode_e'(mode_sel);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MODE_PIN};
        else        st_q <= st_d;
    end

    irq_pin_drv #(.N(NUM_SRC)) u_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .route   (route_cfg),
        .pins_en (!mode_is_msg(cur_mode_q)),
        .pri_n   (irq_pri_n),
        .alt_n   (irq_alt_n)
    );

    irq_msg_ctrl #(.N(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_msg (
        .clk         (clk),
        .rst_n       (rst_n),
        .pending     (pending),
        .mode        (cur_mode_q),
        .single_addr (single_addr),
        .single_data (single_data),
        .vec_addr    (vec_addr),
        .vec_data    (vec_data),
        .done        (msg_done),
        .valid       (msg_valid),
        .addr        (msg_addr),
        .data        (msg_data),
        .src         (msg_src)
    );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
    parameter int N      = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int IW    = (N > 1) ? $clog2(N) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N-1:0]      src_req,
    input logic [N-1:0]      host_mask,
    input logic [1:0]        mode,
    input logic              msg_done,
    input logic              irq_pri_n,
    input logic              irq_alt_n,
    input logic              msg_valid,
    input logic [ADDR_W-1:0] msg_addr,
    input logic [DATA_W-1:0] msg_data,
    input logic [IW-1:0]     msg_src
);
    logic [N-1:0] pend_prev_q;
    logic         in_msg;

    assign in_msg = (mode == 2'b01) || (mode == 2'b10);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_prev_q <= '0;
        else        pend_prev_q <= src_req & ~host_mask;
    end

    AST_PINS_QUIET_IN_MSG: assert property (@(posedge clk) disable iff (!rst_n)
        in_msg |=> (irq_pri_n && irq_alt_n)); // R5

    AST_ALL_MASKED_PINS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (&host_mask) |=> (irq_pri_n && irq_alt_n)); // R4

    AST_WRITE_FROM_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> pend_prev_q[msg_src]); // R6

    AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_done) |=> (msg_valid && $stable(msg_addr)
                                      && $stable(msg_data) && $stable(msg_src))); // R11

    AST_MODE_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |=> $stable(mode)); // R10

    AST_GAP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_done) |=> !msg_valid); // R7
endmodule

bind irq_router irq_router_chk #(.N(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_req   (src_req),
    .host_mask (host_mask),
    .mode      (cur_mode_q),
    .msg_done  (msg_done),
    .irq_pri_n (irq_pri_n),
    .irq_alt_n (irq_alt_n),
    .msg_valid (msg_valid),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data),
    .msg_src   (msg_src)
);

// File: tb/tb_irq_router.sv
module tb_irq_router;
    localparam int N  = 8;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int IW = $clog2(N);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    src_req = '0;
    logic [N-1:0]    host_mask = '0;
    logic [2*N-1:0]  route_cfg = '0;
    logic [1:0]      mode_sel = 2'b00;
    logic [AW-1:0]   single_addr = 32'hFEE0_1000;
    logic [DW-1:0]   single_data = 32'h0000_4021;
    logic [N*AW-1:0] vec_addr;
    logic [N*DW-1:0] vec_data;
    logic            msg_done = 1'b0;
    logic            irq_pri_n, irq_alt_n, msg_valid;
    logic [AW-1:0]   msg_addr;
    logic [DW-1:0]   msg_data;
    logic [IW-1:0]   msg_src;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_router #(.NUM_SRC(N), .ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .host_mask(host_mask),
        .route_cfg(route_cfg), .mode_sel(mode_sel), .single_addr(single_addr),
        .single_data(single_data), .vec_addr(vec_addr), .vec_data(vec_data),
        .msg_done(msg_done), .irq_pri_n(irq_pri_n), .irq_alt_n(irq_alt_n),
        .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data),
        .msg_src(msg_src)
    );

    function automatic logic [AW-1:0] exp_vaddr(int i);
        return 32'h1000_0000 + 32'(i) * 32'h10;
    endfunction
    function automatic logic [DW-1:0] exp_vdata(int i);
        return 32'hA500_0000 + 32'(i);
    endfunction

    task automatic check(input logic ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic idle();
        src_req  = '0;
        mode_sel = 2'b00;
        cycles(4);
    endtask

    task automatic expect_msg(input int s, input logic [AW-1:0] a, input logic [DW-1:0] d,
                              input string req);
        for (int k = 0; k < 20 && !msg_valid; k++) @(negedge clk);
        check(msg_valid == 1'b1, req, 64'(msg_valid), 64'd1);
        check(msg_src == IW'(s), req, 64'(msg_src), 64'(s));
        check(msg_addr == a && msg_data == d, req, {msg_addr, msg_data}, {a, d});
    endtask

    task automatic finish_msg(input string req);
        msg_done = 1'b1;
        @(negedge clk);
        msg_done = 1'b0;
        check(msg_valid == 1'b0, req, 64'(msg_valid), 64'd0);
    endtask

    task automatic t_reset();
        check(irq_pri_n && irq_alt_n && !msg_valid, "R1",
              {61'd0, irq_pri_n, irq_alt_n, msg_valid}, 64'b110);
    endtask

    task automatic t_routing();
        mode_sel  = 2'b00;
        route_cfg = '0;
        route_cfg[1:0] = 2'b01;
        route_cfg[3:2] = 2'b10;
        route_cfg[5:4] = 2'b11;
        route_cfg[7:6] = 2'b00;
        src_req = 8'b0000_0001; cycles(1);
        check({irq_pri_n, irq_alt_n} == 2'b01, "R2", 64'({irq_pri_n, irq_alt_n}), 64'b01);
        src_req = 8'b0000_0010; cycles(1);
        check({irq_pri_n, irq_alt_n} == 2'b10, "R3", 64'({irq_pri_n, irq_alt_n}), 64'b10);
        src_req = 8'b0000_0100; cycles(1);
        check({irq_pri_n, irq_alt_n} == 2'b00, "R3", 64'({irq_pri_n, irq_alt_n}), 64'b00);
        src_req = 8'b0000_1000; cycles(1);
        check({irq_pri_n, irq_alt_n} == 2'b11, "R3", 64'({irq_pri_n, irq_alt_n}), 64'b11);
        mode_sel = 2'b11; src_req = 8'b0000_0001; cycles(2);
        check({irq_pri_n, irq_alt_n} == 2'b01, "R2", 64'({irq_pri_n, irq_alt_n}), 64'b01);
        src_req = '0; cycles(1);
        check({irq_pri_n, irq_alt_n} == 2'b11, "R2", 64'({irq_pri_n, irq_alt_n}), 64'b11);
        idle();
    endtask

    task automatic t_mask();
        bit seen = 0;
        host_mask = 8'b0000_0100;
        src_req   = 8'b0000_0100; cycles(2);
        check({irq_pri_n, irq_alt_n} == 2'b11, "R4", 64'({irq_pri_n, irq_alt_n}), 64'b11);
        mode_sel = 2'b10;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (msg_valid) seen = 1;
        end
        check(!seen, "R4", 64'(seen), 64'd0);
        host_mask = '0;
        expect_msg(2, exp_vaddr(2), exp_vdata(2), "R9");
        finish_msg("R7");
        idle();
    endtask

    task automatic t_single();
        bit seen = 0;
        mode_sel = 2'b01;
        route_cfg[9:8] = 2'b11;
        cycles(2);
        src_req = 8'b0001_0000;
        expect_msg(4, single_addr, single_data, "R8");
        check({irq_pri_n, irq_alt_n} == 2'b11, "R5", 64'({irq_pri_n, irq_alt_n}), 64'b11);
        cycles(3);
        check(msg_valid && msg_src == 3'd4 && msg_addr == single_addr, "R11",
              64'(msg_addr), 64'(single_addr));
        finish_msg("R7");
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (msg_valid) seen = 1;
        end
        check(!seen, "R6", 64'(seen), 64'd0);
        src_req = '0; cycles(2);
        src_req = 8'b0001_0000;
        expect_msg(4, single_addr, single_data, "R6");
        finish_msg("R7");
        idle();
    endtask

    task automatic t_priority();
        mode_sel = 2'b10; cycles(2);
        src_req = 8'b0010_1010;
        expect_msg(1, exp_vaddr(1), exp_vdata(1), "R7");
        finish_msg("R7");
        expect_msg(3, exp_vaddr(3), exp_vdata(3), "R7");
        finish_msg("R7");
        expect_msg(5, exp_vaddr(5), exp_vdata(5), "R9");
        finish_msg("R7");
        idle();
    endtask

    task automatic t_mode_change();
        mode_sel = 2'b10;
        route_cfg[13:12] = 2'b01;
        cycles(2);
        src_req = 8'b0100_0000;
        expect_msg(6, exp_vaddr(6), exp_vdata(6), "R9");
        mode_sel = 2'b00;
        cycles(4);
        check(irq_pri_n == 1'b1 && msg_valid, "R10", 64'(irq_pri_n), 64'd1);
        finish_msg("R7");
        cycles(2);
        check(irq_pri_n == 1'b0, "R10", 64'(irq_pri_n), 64'd0);
        idle();
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            vec_addr[i*AW +: AW] = exp_vaddr(i);
            vec_data[i*DW +: DW] = exp_vdata(i);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        t_reset();
        t_routing();
        t_mask();
        t_single();
        t_priority();
        t_mode_change();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule